// File: doc/BRIEF.md
# DMA Channel Trigger Control Sequencer

This block is the control state machine for one channel of a multi-channel DMA engine. It selects one peripheral event line with a 5-bit select code and records a trigger as pending. It also takes single-cycle software command strobes: run, halt, soft reset, force and clear of the trigger, force and clear of the sync, and error clear. From these it decides when a burst may begin. An external address generator does the address arithmetic. This block sends that generator a one-cycle burst-start pulse and a one-cycle transfer-done pulse. The generator returns a burst-complete strobe and a flag that says the transfer count has reached zero.

The channel can work in three ways. It can start one burst per trigger. In one-shot mode it starts every burst of a transfer from a single trigger. In continuous mode it rearms after a finished transfer and waits for the next trigger. The channel interrupt fires either when a new transfer starts or when it ends. A second trigger that arrives while one is still pending latches an overflow flag. A sync event that arrives while the selected wrap counter is away from its reload point latches a sync error.

Every output is registered. An input sampled at a clock edge shows on the outputs just after that same edge. A peripheral event line that is high at a clock edge counts as one event.

Top module: `dma_chan_ctrl`

## Requirements
- R1: Select code k in 1..17 routes event line `evt_i[k-1]` to the trigger logic. Code 0 and codes 18..31 select no line. A selected event sampled high with the enable set makes `trig_pend_o` go high after that edge.
- R2: With `trig_en_i` low, events never set the pending trigger. `cmd_trig_frc_i` sets it regardless of the enable. `cmd_trig_clr_i` clears it, and a clear wins over a set in the same cycle.
- R3: While the channel is running and idle between bursts, a pending trigger seen at an edge produces a one-cycle `burst_start_o` after the next edge. That burst start also consumes the pending trigger.
- R4: With `oneshot_i` low, each trigger starts exactly one burst. With `oneshot_i` high, after the first burst of a transfer the next burst starts one edge after each burst completion without a trigger, until the count reaches zero.
- R5: A burst completion with `tcount_zero_i` high gives a one-cycle `xfer_done_o` and ends the transfer. The channel then stops (`running_o` low) if `contin_i` is low. If `contin_i` is high it stays running and waits for a new trigger.
- R6: With `chan_irq_en_i` high, `irq_o` pulses together with the first `burst_start_o` of a transfer when `irq_at_end_i` is 0, or together with `xfer_done_o` when it is 1. With `chan_irq_en_i` low, neither of these produces a pulse.
- R7: An enabled event arriving while `trig_pend_o` is high sets `ovf_o`. It pulses `irq_o` only when `ovf_irq_en_i` is high. `cmd_err_clr_i` clears `ovf_o`.
- R8: `sync_i` is ignored unless `sync_en_i` is high. An accepted sync, or `cmd_sync_frc_i`, sets `sync_pend_o`, and `cmd_sync_clr_i` clears it. An accepted sync with `wrap_at_reload_i` low sets `sync_err_o`, which `cmd_err_clr_i` clears.
- R9: Halt stops a channel that is waiting between bursts at the next edge. During a burst it takes effect at the burst completion. The transfer state survives the halt (`xfer_busy_o` stays high), and a run strobe resumes from there.
- R10: Soft reset returns the channel to stopped and clears the pending trigger, the pending sync and the transfer state. It takes priority over a run or a burst start in the same cycle.
- R11: After reset every output is 0. `burst_busy_o` is high while a burst runs or a trigger is pending. `xfer_busy_o` is high while a transfer is open or a trigger is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Peripheral event lines, line k-1 for select code k |
| sel_i | input | SEL_W | Trigger source select code |
| trig_en_i | input | 1 | Peripheral trigger enable |
| oneshot_i | input | 1 | One trigger runs the whole transfer |
| contin_i | input | 1 | Rearm after a finished transfer |
| irq_at_end_i | input | 1 | 0: interrupt at transfer start, 1: at transfer end |
| chan_irq_en_i | input | 1 | Channel interrupt enable |
| ovf_irq_en_i | input | 1 | Overflow interrupt enable |
| sync_en_i | input | 1 | Sync input enable |
| sync_i | input | 1 | Sync event |
| wrap_at_reload_i | input | 1 | Selected wrap counter is at its reload point |
| cmd_run_i | input | 1 | Run strobe |
| cmd_halt_i | input | 1 | Halt strobe |
| cmd_soft_rst_i | input | 1 | Soft reset strobe |
| cmd_trig_frc_i | input | 1 | Force trigger strobe |
| cmd_trig_clr_i | input | 1 | Clear trigger strobe |
| cmd_sync_frc_i | input | 1 | Force sync strobe |
| cmd_sync_clr_i | input | 1 | Clear sync strobe |
| cmd_err_clr_i | input | 1 | Clear overflow and sync error strobe |
| burst_done_i | input | 1 | Burst complete from address generator |
| tcount_zero_i | input | 1 | Transfer count reached zero (valid with burst_done_i) |
| burst_start_o | output | 1 | One-cycle burst start pulse |
| xfer_done_o | output | 1 | One-cycle transfer done pulse |
| irq_o | output | 1 | One-cycle interrupt pulse |
| trig_pend_o | output | 1 | Trigger pending |
| sync_pend_o | output | 1 | Sync pending |
| sync_err_o | output | 1 | Sync error latched |
| xfer_busy_o | output | 1 | Transfer open or pending |
| burst_busy_o | output | 1 | Burst running or pending |
| running_o | output | 1 | Channel running |
| ovf_o | output | 1 | Trigger overflow latched |

## Verification
The bench builds the block with its default parameters: 17 event lines behind a 5-bit select. Random select codes from 0 to 31 therefore reach all the mapped lines, the unused code 0 and the unmapped codes 18..31, and each is checked against a bench function. With the same parameters, directed sequences cover the one-shot chain of bursts, continuous rearm, a halt in the middle of a burst followed by a resume, and both interrupt timings. They also cover the same-cycle conflicts: a force and a clear together, and a soft reset together with a burst that is about to start.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BURST = 2'd2
    } chan_state_e;

    typedef struct packed {
        chan_state_e st;
        logic        trig_pend;
        logic        sync_pend;
        logic        sync_err;
        logic        ovf;
        logic        xfer_act;
        logic        halt_pend;
        logic        bstart;
        logic        xdone;
        logic        irq;
    } chan_regs_t;

endpackage

// File: rtl/dma_trig_sel.sv
module dma_trig_sel #(
    parameter int NUM_SRC = 17,
    parameter int SEL_W   = 5
) (
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               hit_o
);
    logic [NUM_SRC-1:0] match;

    // code k+1 routes line k; codes 0 and above NUM_SRC select nothing
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_line
        assign match[k] = evt_i[k] && (sel_i == SEL_W'(k + 1));
    end

    assign hit_o = |match;
endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_hit_i,
    input  logic trig_en_i,
    input  logic oneshot_i,
    input  logic contin_i,
    input  logic irq_at_end_i,
    input  logic chan_irq_en_i,
    input  logic ovf_irq_en_i,
    input  logic sync_en_i,
    input  logic sync_i,
    input  logic wrap_at_reload_i,
    input  logic cmd_run_i,
    input  logic cmd_halt_i,
    input  logic cmd_soft_rst_i,
    input  logic cmd_trig_frc_i,
    input  logic cmd_trig_clr_i,
    input  logic cmd_sync_frc_i,
    input  logic cmd_sync_clr_i,
    input  logic cmd_err_clr_i,
    input  logic burst_done_i,
    input  logic tcount_zero_i,
    output chan_regs_t regs_o
);
    localparam chan_regs_t REGS_RST = '{st: ST_IDLE, default: '0};

    chan_regs_t regs_d, regs_q;
    logic       trig_set;
    logic       sync_ev;
    logic       halt_now;

    always_comb begin
        regs_d        = regs_q;
        regs_d.bstart = 1'b0;
        regs_d.xdone  = 1'b0;
        regs_d.irq    = 1'b0;

        trig_set = (trig_en_i && evt_hit_i) || cmd_trig_frc_i;
        sync_ev  = sync_en_i && sync_i;
        halt_now = (regs_q.halt_pend || cmd_halt_i) && !cmd_run_i;

        // error flags: clear first, a new event in the same cycle wins
        if (cmd_err_clr_i) begin
            regs_d.ovf      = 1'b0;
            regs_d.sync_err = 1'b0;
        end
        if (trig_en_i && evt_hit_i && regs_q.trig_pend) begin
            regs_d.ovf = 1'b1;
            if (ovf_irq_en_i) regs_d.irq = 1'b1;
        end
        if (sync_ev && !wrap_at_reload_i) regs_d.sync_err = 1'b1;

        if (trig_set) regs_d.trig_pend = 1'b1;
        if (sync_ev || cmd_sync_frc_i) regs_d.sync_pend = 1'b1;

        unique case (regs_q.st)
            ST_IDLE: begin
                if (cmd_run_i) begin
                    regs_d.st        = ST_ARMED;
                    regs_d.halt_pend = 1'b0;
                end
            end
            ST_ARMED: begin
                if (cmd_halt_i && !cmd_run_i) begin
                    regs_d.st = ST_IDLE;
                end else if (regs_q.trig_pend || (oneshot_i && regs_q.xfer_act)) begin
                    regs_d.st        = ST_BURST;
                    regs_d.bstart    = 1'b1;
                    regs_d.trig_pend = trig_set;
                    regs_d.sync_pend = sync_ev || cmd_sync_frc_i;
                    if (!regs_q.xfer_act) begin
                        regs_d.xfer_act = 1'b1;
                        if (chan_irq_en_i && !irq_at_end_i) regs_d.irq = 1'b1;
                    end
                end
            end
            ST_BURST: begin
                regs_d.halt_pend = halt_now;
                if (burst_done_i) begin
                    regs_d.halt_pend = 1'b0;
                    regs_d.st        = halt_now ? ST_IDLE : ST_ARMED;
                    if (tcount_zero_i) begin
                        regs_d.xdone    = 1'b1;
                        regs_d.xfer_act = 1'b0;
                        if (chan_irq_en_i && irq_at_end_i) regs_d.irq = 1'b1;
                        if (!contin_i) regs_d.st = ST_IDLE;
                    end
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase

        if (cmd_trig_clr_i) regs_d.trig_pend = 1'b0;
        if (cmd_sync_clr_i) regs_d.sync_pend = 1'b0;

        if (cmd_soft_rst_i) begin
            regs_d.st        = ST_IDLE;
            regs_d.trig_pend = 1'b0;
            regs_d.sync_pend = 1'b0;
            regs_d.xfer_act  = 1'b0;
            regs_d.halt_pend = 1'b0;
            regs_d.bstart    = 1'b0;
            regs_d.xdone     = 1'b0;
            regs_d.irq       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int NUM_SRC = 17,
    parameter int SEL_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               trig_en_i,
    input  logic               oneshot_i,
    input  logic               contin_i,
    input  logic               irq_at_end_i,
    input  logic               chan_irq_en_i,
    input  logic               ovf_irq_en_i,
    input  logic               sync_en_i,
    input  logic               sync_i,
    input  logic               wrap_at_reload_i,
    input  logic               cmd_run_i,
    input  logic               cmd_halt_i,
    input  logic               cmd_soft_rst_i,
    input  logic               cmd_trig_frc_i,
    input  logic               cmd_trig_clr_i,
    input  logic               cmd_sync_frc_i,
    input  logic               cmd_sync_clr_i,
    input  logic               cmd_err_clr_i,
    input  logic               burst_done_i,
    input  logic               tcount_zero_i,
    output logic               burst_start_o,
    output logic               xfer_done_o,
    output logic               irq_o,
    output logic               trig_pend_o,
    output logic               sync_pend_o,
    output logic               sync_err_o,
    output logic               xfer_busy_o,
    output logic               burst_busy_o,
    output logic               running_o,
    output logic               ovf_o
);
    logic       evt_hit;
    chan_regs_t regs;

    dma_trig_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
        .evt_i (evt_i),
        .sel_i (sel_i),
        .hit_o (evt_hit)
    );

    dma_chan_fsm u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .evt_hit_i        (evt_hit),
        .trig_en_i        (trig_en_i),
        .oneshot_i        (oneshot_i),
        .contin_i         (contin_i),
        .irq_at_end_i     (irq_at_end_i),
        .chan_irq_en_i    (chan_irq_en_i),
        .ovf_irq_en_i     (ovf_irq_en_i),
        .sync_en_i        (sync_en_i),
        .sync_i           (sync_i),
        .wrap_at_reload_i (wrap_at_reload_i),
        .cmd_run_i        (cmd_run_i),
        .cmd_halt_i       (cmd_halt_i),
        .cmd_soft_rst_i   (cmd_soft_rst_i),
        .cmd_trig_frc_i   (cmd_trig_frc_i),
        .cmd_trig_clr_i   (cmd_trig_clr_i),
        .cmd_sync_frc_i   (cmd_sync_frc_i),
        .cmd_sync_clr_i   (cmd_sync_clr_i),
        .cmd_err_clr_i    (cmd_err_clr_i),
        .burst_done_i     (burst_done_i),
        .tcount_zero_i    (tcount_zero_i),
        .regs_o           (regs)
    );

    assign burst_start_o = regs.bstart;
    assign xfer_done_o   = regs.xdone;
    assign irq_o         = regs.irq;
    assign trig_pend_o   = regs.trig_pend;
    assign sync_pend_o   = regs.sync_pend;
    assign sync_err_o    = regs.sync_err;
    assign ovf_o         = regs.ovf;
    assign running_o     = (regs.st != ST_IDLE);
    assign burst_busy_o  = (regs.st == ST_BURST) || regs.trig_pend;
    assign xfer_busy_o   = regs.xfer_act || regs.trig_pend;
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic trig_en_i,
    input logic cmd_trig_frc_i,
    input logic cmd_trig_clr_i,
    input logic cmd_soft_rst_i,
    input logic sync_en_i,
    input logic tcount_zero_i,
    input logic burst_start_o,
    input logic xfer_done_o,
    input logic trig_pend_o,
    input logic sync_pend_o,
    input logic sync_err_o,
    input logic burst_busy_o,
    input logic running_o,
    input logic ovf_o
);
    // R2
    trig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_pend_o) |-> ($past(trig_en_i) || $past(cmd_trig_frc_i)));

    // R2
    trig_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_trig_clr_i |=> !trig_pend_o);

    // R3
    burst_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start_o |-> (running_o && burst_busy_o));

    // R5
    done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_o |-> $past(tcount_zero_i));

    // R5
    start_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({burst_start_o, xfer_done_o}));

    // R7
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(trig_pend_o));

    // R8
    sync_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err_o) |-> $past(sync_en_i));

    // R10
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_soft_rst_i |=> (!running_o && !trig_pend_o && !sync_pend_o && !burst_start_o));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk u_chk (.*);

// File: tb/dma_chan_ctrl_bench.sv
`timescale 1ns/1ps
module dma_chan_ctrl_bench;
    localparam int NUM_SRC = 17;
    localparam int SEL_W   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_SRC-1:0] evt_i = '0;
    logic [SEL_W-1:0]   sel_i = '0;
    logic trig_en_i = 0, oneshot_i = 0, contin_i = 0, irq_at_end_i = 0;
    logic chan_irq_en_i = 0, ovf_irq_en_i = 0, sync_en_i = 0, sync_i = 0;
    logic wrap_at_reload_i = 0;
    logic cmd_run_i = 0, cmd_halt_i = 0, cmd_soft_rst_i = 0, cmd_trig_frc_i = 0;
    logic cmd_trig_clr_i = 0, cmd_sync_frc_i = 0, cmd_sync_clr_i = 0, cmd_err_clr_i = 0;
    logic burst_done_i = 0, tcount_zero_i = 0;
    logic burst_start_o, xfer_done_o, irq_o, trig_pend_o, sync_pend_o, sync_err_o;
    logic xfer_busy_o, burst_busy_o, running_o, ovf_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_chan_ctrl #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_dma_chan_ctrl (.*);

    function automatic logic exp_hit(input logic [SEL_W-1:0] s, input logic [NUM_SRC-1:0] e);
        if (s >= 1 && s <= NUM_SRC) return e[s-1];
        return 1'b0;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // one edge, sample 1 ns after it; then drop every strobe
    task automatic step();
        @(posedge clk);
        #1;
        cmd_run_i = 0; cmd_halt_i = 0; cmd_soft_rst_i = 0; cmd_trig_frc_i = 0;
        cmd_trig_clr_i = 0; cmd_sync_frc_i = 0; cmd_sync_clr_i = 0; cmd_err_clr_i = 0;
        burst_done_i = 0; tcount_zero_i = 0; sync_i = 0; evt_i = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11 reset state
        chk("R11", "burst_start", burst_start_o, 0);
        chk("R11", "running", running_o, 0);
        chk("R11", "trig_pend", trig_pend_o, 0);
        chk("R11", "busy", xfer_busy_o | burst_busy_o | irq_o | ovf_o | sync_err_o, 0);

        // R1 / R2 directed
        trig_en_i = 1; sel_i = 3; evt_i[2] = 1; step();
        chk("R1", "line 2 via code 3", trig_pend_o, 1);
        chk("R11", "burst_busy on pending", burst_busy_o, 1);
        cmd_trig_clr_i = 1; step();
        chk("R2", "clear", trig_pend_o, 0);
        trig_en_i = 0; evt_i[2] = 1; step();
        chk("R2", "disabled ignored", trig_pend_o, 0);
        cmd_trig_frc_i = 1; step();
        chk("R2", "force", trig_pend_o, 1);
        cmd_trig_clr_i = 1; cmd_trig_frc_i = 1; step();
        chk("R2", "clear wins", trig_pend_o, 0);

        // R1 random selection
        trig_en_i = 1;
        for (int i = 0; i < 60; i++) begin
            logic [SEL_W-1:0]   s;
            logic [NUM_SRC-1:0] e;
            s = SEL_W'($urandom % 32);
            e = NUM_SRC'($urandom);
            if (i < 4) s = (i == 0) ? 5'd0 : (i == 1) ? 5'd17 : (i == 2) ? 5'd18 : 5'd31;
            if (i < 4) e = '1;
            sel_i = s; evt_i = e; step();
            chk("R1", $sformatf("select code %0d", s), trig_pend_o, exp_hit(s, e));
            cmd_trig_clr_i = 1; step();
        end
        sel_i = 3;

        // R3 / R6 start mode, R4 no one-shot
        chan_irq_en_i = 1; irq_at_end_i = 0;
        cmd_run_i = 1; step();
        chk("R5", "running after run", running_o, 1);
        cmd_trig_frc_i = 1; step();
        chk("R3", "no start yet", burst_start_o, 0);
        step();
        chk("R3", "burst start", burst_start_o, 1);
        chk("R6", "irq at start", irq_o, 1);
        chk("R3", "pending consumed", trig_pend_o, 0);
        chk("R11", "xfer_busy", xfer_busy_o, 1);
        step();
        chk("R3", "start one cycle", burst_start_o, 0);
        burst_done_i = 1; step();
        chk("R11", "burst_busy idle", burst_busy_o, 0);
        step(); step();
        chk("R4", "no burst without trigger", burst_start_o, 0);
        cmd_trig_frc_i = 1; step(); step();
        chk("R4", "second trigger burst", burst_start_o, 1);
        chk("R6", "no irq mid transfer", irq_o, 0);
        burst_done_i = 1; tcount_zero_i = 1; step();
        chk("R5", "xfer_done", xfer_done_o, 1);
        chk("R5", "stopped", running_o, 0);
        chk("R6", "no end irq in start mode", irq_o, 0);

        // R5 continuous, R6 end mode and gating
        irq_at_end_i = 1; contin_i = 1;
        cmd_run_i = 1; step();
        cmd_trig_frc_i = 1; step(); step();
        chk("R3", "burst start cont", burst_start_o, 1);
        chk("R6", "no start irq in end mode", irq_o, 0);
        burst_done_i = 1; tcount_zero_i = 1; step();
        chk("R6", "irq at end", irq_o, 1);
        chk("R5", "continuous stays running", running_o, 1);
        step();
        chk("R5", "waits for trigger", burst_start_o, 0);
        chan_irq_en_i = 0;
        cmd_trig_frc_i = 1; step(); step();
        burst_done_i = 1; tcount_zero_i = 1; step();
        chk("R6", "enable gates irq", irq_o, 0);
        cmd_halt_i = 1; step();
        chk("R9", "halt while armed", running_o, 0);

        // R4 one-shot, R9 halt mid burst and resume
        contin_i = 0; oneshot_i = 1;
        cmd_run_i = 1; step();
        cmd_trig_frc_i = 1; step(); step();
        chk("R4", "first burst", burst_start_o, 1);
        cmd_halt_i = 1; step();
        chk("R9", "running during burst", running_o, 1);
        burst_done_i = 1; step();
        chk("R9", "stopped at boundary", running_o, 0);
        chk("R9", "transfer kept", xfer_busy_o, 1);
        step();
        chk("R9", "no burst while halted", burst_start_o, 0);
        cmd_run_i = 1; step();
        chk("R9", "resumed", running_o, 1);
        step();
        chk("R4", "one-shot auto burst", burst_start_o, 1);
        burst_done_i = 1; step(); step();
        chk("R4", "one-shot next burst", burst_start_o, 1);
        burst_done_i = 1; tcount_zero_i = 1; step();
        chk("R4", "one-shot done", xfer_done_o, 1);
        oneshot_i = 0;

        // R7 overflow
        ovf_irq_en_i = 1; trig_en_i = 1; sel_i = 3;
        evt_i[2] = 1; step();
        chk("R7", "no ovf first", ovf_o, 0);
        evt_i[2] = 1; step();
        chk("R7", "ovf set", ovf_o, 1);
        chk("R7", "ovf irq", irq_o, 1);
        cmd_err_clr_i = 1; step();
        chk("R7", "ovf cleared", ovf_o, 0);
        ovf_irq_en_i = 0; evt_i[2] = 1; step();
        chk("R7", "ovf again", ovf_o, 1);
        chk("R7", "ovf irq masked", irq_o, 0);
        cmd_err_clr_i = 1; cmd_trig_clr_i = 1; step();

        // R8 sync
        sync_en_i = 0; sync_i = 1; step();
        chk("R8", "sync ignored", sync_pend_o | sync_err_o, 0);
        sync_en_i = 1; wrap_at_reload_i = 1; sync_i = 1; step();
        chk("R8", "sync pending", sync_pend_o, 1);
        chk("R8", "no error at reload", sync_err_o, 0);
        cmd_sync_clr_i = 1; step();
        chk("R8", "sync cleared", sync_pend_o, 0);
        wrap_at_reload_i = 0; sync_i = 1; step();
        chk("R8", "sync error", sync_err_o, 1);
        cmd_err_clr_i = 1; cmd_sync_clr_i = 1; step();
        chk("R8", "sync error cleared", sync_err_o, 0);
        cmd_sync_frc_i = 1; step();
        chk("R8", "sync force", sync_pend_o, 1);

        // R10 soft reset
        cmd_trig_frc_i = 1; step();
        cmd_run_i = 1; step();
        chk("R10", "armed before reset", running_o, 1);
        cmd_soft_rst_i = 1; step();
        chk("R10", "stopped", running_o, 0);
        chk("R10", "no burst", burst_start_o, 0);
        chk("R10", "trig cleared", trig_pend_o, 0);
        chk("R10", "sync cleared", sync_pend_o, 0);
        step();
        chk("R10", "stays idle", burst_start_o | running_o, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule